// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope analog-to-digital converter. An external integrator, an input/reference switch and a zero-crossing comparator form the analog half. When a conversion is requested, the sequencer releases the integrator's discharge switch. It routes the unknown input to the integrator for a fixed window of exactly one full counter period. The counter then rolls over to zero, and at that moment the sequencer flips the switch to the opposite-polarity reference. It keeps counting for as long as the comparator reports that the integrator has not yet returned to zero.

The count at the moment of the zero crossing is the measurement. Both phases are timed by the same clock, so the result depends only on the ratio of input to reference and not on the clock rate. If the integrator is still above zero when the counter would overflow a second time, the conversion ends with a full-scale result and an over-range flag. Between conversions the sequencer holds the integrator in discharge. Completion is marked by a single-cycle strobe, and the last result stays available until the next conversion completes.

Top module: `dslope_seq`

## Requirements
- R1: After reset the block is idle: `int_clear`=1, `sel_ref`=0, `count`=0, `result`=0, `over_range`=0, `done`=0.
- R2: A `start` sampled high while idle begins a conversion on that clock edge. From the next cycle `int_clear`=0, `sel_ref`=0 (input selected), and `count` starts at 0 and rises by one every cycle.
- R3: The input phase lasts exactly 2^CNT_W cycles. On the edge where `count` is all ones, `count` wraps to 0 and `sel_ref` goes to 1 (reference selected).
- R4: In the reference phase, `count` rises by one on each edge where `cmp_hi`=1. On the first edge where `cmp_hi`=0, that count is captured into `result` with `over_range`=0. With an ideal integrator this makes `result` = ceil(2^CNT_W · Vin / Vref).
- R5: If `cmp_hi`=1 on an edge where `count` is all ones in the reference phase, the conversion ends with `result` all ones and `over_range`=1.
- R6: If `cmp_hi` first reads 0 exactly when `count` is all ones in the reference phase, `result` is all ones and `over_range`=0.
- R7: `done` is high for exactly one cycle: the cycle after the capture edge. On the following cycle the block is idle again, with `int_clear`=1 and `count`=0.
- R8: `result` and `over_range` change only on a capture edge. They hold through idle time and through the next conversion until it completes.
- R9: `start` has no effect while a conversion is in progress. The input phase keeps its full length and the result is unchanged.
- R10: Scaling input and reference by the same factor gives the same `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled while idle |
| cmp_hi | input | 1 | Zero-crossing comparator, 1 while the integrator is above zero |
| sel_ref | output | 1 | Switch select: 0 = unknown input, 1 = reference |
| int_clear | output | 1 | Integrator discharge, high while idle |
| count | output | CNT_W | Running phase counter |
| result | output | CNT_W | Last completed conversion value |
| over_range | output | 1 | Last conversion exceeded full scale |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the sequencer with CNT_W=6, so each input window is 64 cycles and a conversion never exceeds about 130 cycles. At that width the exact-full-scale edge (Vin/Vref = 63/64) and true over-range (Vin = Vref) sit only a few cycles apart and are both reached directly. A behavioural integrator in the bench produces `cmp_hi`, so results follow from the ceiling formula. The same short window also makes a mid-conversion `start` poke and a same-ratio pair cheap to run.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_INTEG = 2'd1,
      PH_DEINT = 2'd2,
      PH_DONE  = 2'd3
   } phase_t;
endpackage

// File: rtl/dslope_counter.sv
module dslope_counter #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] cnt,
   output logic         at_max
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   generate
      if (W < 2) begin : g_bad_width
         $error("dslope_counter: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (en)  cnt <= cnt + 1'b1;
   end

   assign at_max = (cnt == TOP);

   // R3: an enabled count at the top value rolls over to zero
   a_r3_rollover: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && at_max) |=> (cnt == '0));
endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl
   import dslope_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   cmp_hi,
   input  logic   at_max,
   output phase_t phase,
   output logic   cnt_clr,
   output logic   cnt_en,
   output logic   cap,
   output logic   cap_ovr
);
   phase_t nxt;

   always_comb begin
      nxt = phase;
      case (phase)
         PH_IDLE:  if (start)  nxt = PH_INTEG;
         PH_INTEG: if (at_max) nxt = PH_DEINT;
         PH_DEINT: if (cap)    nxt = PH_DONE;
         default:              nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= nxt;
   end

   assign cap     = (phase == PH_DEINT) && (!cmp_hi || at_max);
   assign cap_ovr = cmp_hi;
   assign cnt_clr = (phase == PH_IDLE) || (phase == PH_DONE);
   assign cnt_en  = (phase == PH_INTEG) || ((phase == PH_DEINT) && cmp_hi && !at_max);

   // R9: a request during the input window does not cut it short
   a_r9_window_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_INTEG && !at_max) |=> (phase == PH_INTEG));
   // R7: the done phase never lasts longer than one cycle
   a_r7_done_once: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DONE) |=> (phase == PH_IDLE));
endmodule

// File: rtl/dslope_result.sv
module dslope_result #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap,
   input  logic         cap_ovr,
   input  logic [W-1:0] cnt,
   output logic [W-1:0] result,
   output logic         over_range
);
   localparam logic [W-1:0] FULL = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result     <= '0;
         over_range <= 1'b0;
      end else if (cap) begin
         result     <= cap_ovr ? FULL : cnt;
         over_range <= cap_ovr;
      end
   end

   // R8: stored value moves only on a capture
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> ($stable(result) && $stable(over_range)));
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
   import dslope_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cmp_hi,
   output logic             sel_ref,
   output logic             int_clear,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] result,
   output logic             over_range,
   output logic             done
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   phase_t phase;
   logic   cnt_clr, cnt_en, at_max, cap, cap_ovr;

   dslope_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .cmp_hi (cmp_hi),
      .at_max (at_max),
      .phase  (phase),
      .cnt_clr(cnt_clr),
      .cnt_en (cnt_en),
      .cap    (cap),
      .cap_ovr(cap_ovr)
   );

   dslope_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .en    (cnt_en),
      .cnt   (count),
      .at_max(at_max)
   );

   dslope_result #(.W(CNT_W)) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap       (cap),
      .cap_ovr   (cap_ovr),
      .cnt       (count),
      .result    (result),
      .over_range(over_range)
   );

   assign sel_ref   = (phase == PH_DEINT);
   assign int_clear = (phase == PH_IDLE);
   assign done      = (phase == PH_DONE);

   // R3: the switch flips to the reference exactly as the counter wraps
   a_r3_switch_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_ref) |-> (count == '0 && $past(count) == CMAX));
   // R4: a low comparator in the reference phase ends the conversion with the count
   a_r4_stop_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ref && !cmp_hi) |=> (done && !over_range && result == $past(count)));
   // R5: still high at the counter top means over-range at full scale
   a_r5_over_full: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ref && cmp_hi && count == CMAX) |=> (done && over_range && result == CMAX));
   // R7: single-cycle completion strobe
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && int_clear));
   // R2: the counter sits at zero while the integrator is discharged
   a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      int_clear |-> (count == '0 && !sel_ref));
endmodule

// File: tb/dslope_seq_test.sv
module dslope_seq_test;
   localparam int TCLK = 10;
   localparam int W    = 6;
   localparam int T    = 1 << W;
   localparam int MAXV = T - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         cmp_hi;
   logic         sel_ref, int_clear, over_range, done;
   logic [W-1:0] count, result;

   int checks = 0;
   int failures = 0;
   int vin = 0;
   int vref = 1;
   int integ = 0;
   int last_res = 0;
   int last_ovr = 0;
   int ratio_a = -1;
   int scoreboard[$];

   always #(TCLK/2) clk = ~clk;

   dslope_seq #(.CNT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmp_hi(cmp_hi),
      .sel_ref(sel_ref), .int_clear(int_clear), .count(count),
      .result(result), .over_range(over_range), .done(done)
   );

   // behavioural integrator: ramps up on the input, down on the reference
   always @(posedge clk) begin
      if (int_clear)     integ <= 0;
      else if (!sel_ref) integ <= integ + vin;
      else               integ <= integ - vref;
   end
   assign cmp_hi = (integ > 0);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: compare each completed conversion against the scoreboard
   always @(negedge clk) begin
      if (rst_n && done) begin
         int e;
         if (scoreboard.size() == 0) begin
            chk(1'b0, "R4 unexpected done", 1, 0);
         end else begin
            e = scoreboard.pop_front();
            chk(int'(result) == (e & MAXV), "R4/R5/R6 result", int'(result), e & MAXV);
            chk(int'(over_range) == (e >> W), "R5/R6 over_range", int'(over_range), e >> W);
         end
      end
   end

   task automatic convert(input int vi, input int vr, input bit poke, output int got);
      int j, ovr, res, n;
      j   = (T * vi + vr - 1) / vr;
      ovr = (j > MAXV) ? 1 : 0;
      res = ovr ? MAXV : j;
      scoreboard.push_back((ovr << W) | res);
      vin  = vi;
      vref = vr;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(int_clear == 1'b0, "R2 int_clear released", int'(int_clear), 0);
      chk(sel_ref == 1'b0, "R2 input selected", int'(sel_ref), 0);
      chk(count == '0, "R2 count starts at zero", int'(count), 0);
      chk(int'(result) == last_res, "R8 result held into next conversion", int'(result), last_res);
      n = 1;
      forever begin
         @(negedge clk);
         start = poke && (n == 10);
         if (sel_ref) break;
         n++;
         if (n == 5) chk(int'(count) == 4, "R2 count per cycle", int'(count), 4);
      end
      start = 1'b0;
      chk(n == T, poke ? "R9 window length with start poke" : "R3 window length", n, T);
      chk(count == '0, "R3 count wraps at switch", int'(count), 0);
      while (!done) @(negedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
      chk(int_clear == 1'b1, "R7 back to idle", int'(int_clear), 1);
      chk(int'(result) == res, "R8 result held after done", int'(result), res);
      chk(int'(over_range) == ovr, "R8 over_range held after done", int'(over_range), ovr);
      last_res = res;
      last_ovr = ovr;
      got = int'(result);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      int got;
      repeat (3) @(negedge clk);
      chk(int_clear == 1'b1, "R1 int_clear", int'(int_clear), 1);
      chk(sel_ref == 1'b0, "R1 sel_ref", int'(sel_ref), 0);
      chk(count == '0, "R1 count", int'(count), 0);
      chk(result == '0, "R1 result", int'(result), 0);
      chk(over_range == 1'b0, "R1 over_range", int'(over_range), 0);
      chk(done == 1'b0, "R1 done", int'(done), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      convert(8, 16, 1'b0, got);   // R4 mid-scale 32
      ratio_a = got;
      convert(0, 16, 1'b0, got);   // R4 zero input
      convert(16, 16, 1'b0, got);  // R5 over-range
      convert(63, 64, 1'b0, got);  // R6 exactly full scale
      convert(3, 7, 1'b0, got);    // R4 rounded up to 28
      convert(10, 20, 1'b0, got);  // R10 same ratio as first
      chk(got == ratio_a, "R10 ratio independence", got, ratio_a);
      convert(5, 16, 1'b1, got);   // R9 start poked during the window
      convert(1, 16, 1'b0, got);   // R4 small input
      repeat (4) @(negedge clk);
      chk(int'(result) == last_res, "R8 result held while idle", int'(result), last_res);
      chk(scoreboard.size() == 0, "R4 all conversions completed", scoreboard.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule